// File: doc/BRIEF.md
# Bus-Cycle Trace Timestamp Unit

This block sits on a fast local clock and watches an external bus: its slower bus clock, its active-low read and write strobes, and its address and data lines. It marks each bus transaction with a timestamp. The timestamp counts rising edges of the external bus clock, sampled in the local domain, and not local clock cycles. A trace record therefore gives the bus time of each access directly.

The external clock and both strobes pass through flip-flop synchronisers before any logic uses them. The address and data lines pass through a register pipeline of the same depth, so that they line up with the synchronised strobes. When a synchronised strobe falls, the block captures one record and offers it on a valid/ready stream. The record holds the timestamp current at that moment, the direction, the address and the data. If a new access arrives while a record is still unaccepted, the waiting record is kept and a sticky overflow flag is raised.

Top module: `trace_stamp`

## Requirements
- R1: The timestamp advances by exactly one, two local cycles after the external clock input rises. A transaction detected on the same local cycle as that increment carries the value from before the increment.
- R2: While the external clock input does not rise, the timestamp does not change, however many local cycles pass.
- R3: A falling strobe leads to `recValid` high on the third rising local clock edge after the fall, and not earlier.
- R4: A record is packed MSB-first as {timestamp[31:0], rw, addr[22:0], data[15:0]}. `rw` is 1 for a read and 0 for a write. addr and data are the bus values present when the strobe fell.
- R5: While `recValid` is high and `recReady` is low, `recValid` stays high and `recData` does not change. A cycle with both high consumes the record.
- R6: Each strobe fall yields exactly one record. A strobe held low yields no further records.
- R7: A strobe fall while a record waits and `recReady` is low sets `ovfFlag` and keeps the waiting record unchanged.
- R8: `ovfFlag` stays set until `ovfClr` is high on a clock edge. It then clears.
- R9: A synchronous reset (`rst` high) clears the timestamp, the synchronisers, `recValid` and `ovfFlag`.
- R10: The timestamp wraps from all ones to zero without any indication.
- R11: If the read and write strobes fall on the same cycle, a single read record is produced (`rw` = 1).
- R12: If a new transaction is detected on the same cycle that the waiting record is accepted, the new record is loaded and `ovfFlag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| busClk | input | 1 | External bus clock, asynchronous to clk |
| busRdN | input | 1 | Read strobe, active low |
| busWrN | input | 1 | Write strobe, active low |
| busAddr | input | 23 | Bus word address |
| busData | input | 16 | Bus data |
| recReady | input | 1 | Consumer accepts the record |
| ovfClr | input | 1 | Clears the overflow flag |
| recValid | output | 1 | A record is offered |
| recData | output | 72 | Trace record |
| ovfFlag | output | 1 | Sticky overflow |

## Verification
The bench targets the cycle where an external clock edge and a strobe fall meet. A design that counts one stage early or late stamps those records off by one. It checks the exact valid latency and that a strobe held low produces no extra records. Both would break in a level-triggered detector. It tests an acceptance and a new access on the same cycle, where a wrong priority would raise a false overflow or lose the record. It checks simultaneous read and write strobes, and wrap-around on a narrow counter instance, where a bad width or saturation would show.

// File: rtl/trace_stamp_pkg.sv
package trace_stamp_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic tsInc;        // advance the timestamp
    logic capture;      // load a new record
    logic captureRead;  // direction of the record being loaded
  } trace_ctrl_t;

endpackage

// File: rtl/trace_stamp_ctrl.sv
module trace_stamp_ctrl
  import trace_stamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        busClk,
  input  logic        busRdN,
  input  logic        busWrN,
  input  logic        recReady,
  input  logic        ovfClr,
  output logic        recValid,
  output logic        ovfFlag,
  output trace_ctrl_t ctrlOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] clkChain;
  logic [LAST:0] rdChain;
  logic [LAST:0] wrChain;
  logic          rdPrev;
  logic          wrPrev;
  logic          clkNew;
  logic          clkOld;
  logic          rdFall;
  logic          wrFall;
  logic          startAny;
  logic          canLoad;

  // Oldest two clock samples form the old/new pair used for edge detection.
  assign clkNew   = clkChain[LAST-1];
  assign clkOld   = clkChain[LAST];
  assign rdFall   = rdPrev & ~rdChain[LAST];
  assign wrFall   = wrPrev & ~wrChain[LAST];
  assign startAny = rdFall | wrFall;
  assign canLoad  = ~recValid | recReady;

  always_comb begin
    ctrlOut.tsInc       = ~clkOld & clkNew;
    ctrlOut.capture     = startAny & canLoad;
    ctrlOut.captureRead = rdFall;      // read wins when both strobes fall
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkChain <= '0;
      rdChain  <= '1;
      wrChain  <= '1;
      rdPrev   <= 1'b1;
      wrPrev   <= 1'b1;
      recValid <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      clkChain <= {clkChain[LAST-1:0], busClk};
      rdChain  <= {rdChain[LAST-1:0], busRdN};
      wrChain  <= {wrChain[LAST-1:0], busWrN};
      rdPrev   <= rdChain[LAST];
      wrPrev   <= wrChain[LAST];
      if (startAny && canLoad)   recValid <= 1'b1;
      else if (recValid && recReady) recValid <= 1'b0;
      if (startAny && !canLoad)  ovfFlag <= 1'b1;
      else if (ovfClr)           ovfFlag <= 1'b0;
    end
  end

  // R8: the flag holds until a clear arrives
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovfFlag && !ovfClr |=> ovfFlag);

  // R7: overflow only rises while a record was waiting, and it stays waiting
  p_ovf_pending_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovfFlag) |-> $past(recValid) && recValid);

  // R5: an offered record is not withdrawn before it is taken
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (rst)
    recValid && !recReady |=> recValid);

endmodule

// File: rtl/trace_stamp_dp.sv
module trace_stamp_dp
  import trace_stamp_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int ADDR_W      = 23,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  trace_ctrl_t                   ctrlIn,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busData,
  input  logic                          recValid,
  input  logic                          recReady,
  output logic [TS_W+ADDR_W+DATA_W:0]   recData
);

  localparam int REC_W = TS_W + 1 + ADDR_W + DATA_W;

  logic [TS_W-1:0]   tsCount;
  logic [ADDR_W-1:0] addrPipe [SYNC_STAGES];
  logic [DATA_W-1:0] dataPipe [SYNC_STAGES];
  logic [REC_W-1:0]  recQ;

  // Address and data follow the same depth as the strobe synchronisers.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_pipe
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        addrPipe[0] <= busAddr;
        dataPipe[0] <= busData;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        addrPipe[s] <= addrPipe[s-1];
        dataPipe[s] <= dataPipe[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsCount <= '0;
      recQ    <= '0;
    end else begin
      if (ctrlIn.tsInc) tsCount <= tsCount + 1'b1;
      if (ctrlIn.capture)
        recQ <= {tsCount, ctrlIn.captureRead,
                 addrPipe[SYNC_STAGES-1], dataPipe[SYNC_STAGES-1]};
    end
  end

  assign recData = recQ;

  // R1: the timestamp never jumps by more than one step
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    tsCount != $past(tsCount) |-> tsCount == TS_W'($past(tsCount) + 1'b1));

  // R5: a waiting record keeps its contents
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    recValid && !recReady |=> $stable(recData));

endmodule

// File: rtl/trace_stamp.sv
module trace_stamp
  import trace_stamp_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int ADDR_W      = 23,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        busClk,
  input  logic                        busRdN,
  input  logic                        busWrN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busData,
  input  logic                        recReady,
  input  logic                        ovfClr,
  output logic                        recValid,
  output logic [TS_W+ADDR_W+DATA_W:0] recData,
  output logic                        ovfFlag
);

  trace_ctrl_t ctrlBus;

  trace_stamp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .busClk(busClk), .busRdN(busRdN), .busWrN(busWrN),
    .recReady(recReady), .ovfClr(ovfClr), .recValid(recValid),
    .ovfFlag(ovfFlag), .ctrlOut(ctrlBus)
  );

  trace_stamp_dp #(.TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .ctrlIn(ctrlBus), .busAddr(busAddr),
    .busData(busData), .recValid(recValid), .recReady(recReady),
    .recData(recData)
  );

endmodule

// File: tb/trace_stamp_bench.sv
module trace_stamp_bench;

  logic        clk = 1'b0;
  logic        rst, busClk, busRdN, busWrN, recReady, ovfClr;
  logic [22:0] busAddr;
  logic [15:0] busData;
  logic        recValid, ovfFlag, narValid, narOvf;
  logic [71:0] recData;
  logic [43:0] narData;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expTs = '0;

  always #5 clk = ~clk;

  trace_stamp u_trace_stamp (
    .clk(clk), .rst(rst), .busClk(busClk), .busRdN(busRdN), .busWrN(busWrN),
    .busAddr(busAddr), .busData(busData), .recReady(recReady), .ovfClr(ovfClr),
    .recValid(recValid), .recData(recData), .ovfFlag(ovfFlag)
  );

  // Narrow timestamp copy to reach wrap-around quickly.
  trace_stamp #(.TS_W(4)) u_trace_stamp_narrow (
    .clk(clk), .rst(rst), .busClk(busClk), .busRdN(busRdN), .busWrN(busWrN),
    .busAddr(busAddr), .busData(busData), .recReady(recReady), .ovfClr(ovfClr),
    .recValid(narValid), .recData(narData), .ovfFlag(narOvf)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [71:0] act, input logic [71:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busPulse();
    busClk = 1'b1; tick(3);
    busClk = 1'b0; tick(3);
    expTs++;
  endtask

  task automatic drain();
    recReady = 1'b1; tick(1); recReady = 1'b0;
  endtask

  // {isRead, addr, data, clock rises before the access}
  localparam logic [47:0] VEC [5] = '{
    {1'b1, 23'h000123, 16'hBEEF, 8'd3},
    {1'b0, 23'h7FFFFF, 16'h0000, 8'd0},
    {1'b1, 23'h2AAAAA, 16'h5A5A, 8'd7},
    {1'b0, 23'h000001, 16'hFFFF, 8'd9},
    {1'b1, 23'h155555, 16'h8001, 8'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; busClk = 1'b0; busRdN = 1'b1; busWrN = 1'b1;
    recReady = 1'b0; ovfClr = 1'b0; busAddr = '0; busData = '0;
    tick(4);
    rst = 1'b0;
    tick(3);
    check(72'(recValid), 72'd0, "R9 valid low after reset");
    check(72'(ovfFlag), 72'd0, "R9 overflow low after reset");

    // Table walk: timestamp, fields, latency, single record per fall.
    for (int i = 0; i < 5; i++) begin
      logic [47:0] v;
      v = VEC[i];
      for (int k = 0; k < int'(v[7:0]); k++) busPulse();
      tick(2);
      busAddr = v[46:24]; busData = v[23:8];
      if (v[47]) busRdN = 1'b0; else busWrN = 1'b0;
      tick(2);
      check(72'(recValid), 72'd0, "R3 no record before third edge");
      tick(1);
      check(72'(recValid), 72'd1, "R3 record on third edge");
      check(recData, {expTs, v[47], v[46:24], v[23:8]}, "R4 R2 record contents");
      check(72'(narData[43:40]), 72'(expTs[3:0]), "R10 narrow timestamp wraps");
      tick(2);
      check(72'(recValid), 72'd1, "R5 record held without ready");
      drain();
      check(72'(recValid), 72'd0, "R5 record consumed");
      tick(4);
      check(72'(recValid), 72'd0, "R6 held strobe gives no second record");
      busRdN = 1'b1; busWrN = 1'b0 | 1'b1;
      tick(3);
    end
    check(72'(expTs > 16), 72'd1, "R10 wrap range reached");

    // R1: clock rise on the same tick as strobe fall is counted.
    busClk = 1'b1; busRdN = 1'b0; busAddr = 23'h11; busData = 16'h22;
    tick(3);
    check(72'(recData[71:40]), 72'(expTs + 1), "R1 edge with strobe counted");
    expTs++;
    drain(); busClk = 1'b0; busRdN = 1'b1; tick(4);

    // R1: clock rise one tick after the fall increments after capture.
    busRdN = 1'b0; tick(1);
    busClk = 1'b1; tick(2);
    check(72'(recData[71:40]), 72'(expTs), "R1 late edge not in record");
    expTs++;
    drain(); busClk = 1'b0; busRdN = 1'b1; tick(4);

    // R11: both strobes together.
    busRdN = 1'b0; busWrN = 1'b0; busAddr = 23'h33; tick(3);
    check(72'(recData[39]), 72'd1, "R11 simultaneous strobes record read");
    drain(); tick(2);
    check(72'(recValid), 72'd0, "R11 single record for both strobes");
    busRdN = 1'b1; busWrN = 1'b1; tick(4);

    // R7/R8: overflow keeps the first record.
    busWrN = 1'b0; busAddr = 23'h0A; busData = 16'h0A0A; tick(3);
    busWrN = 1'b1; tick(3);
    busRdN = 1'b0; busAddr = 23'h0B; busData = 16'h0B0B; tick(3);
    check(72'(ovfFlag), 72'd1, "R7 overflow set");
    check(recData, {expTs, 1'b0, 23'h0A, 16'h0A0A}, "R7 waiting record kept");
    tick(5);
    check(72'(ovfFlag), 72'd1, "R8 overflow sticky");
    ovfClr = 1'b1; tick(1); ovfClr = 1'b0;
    check(72'(ovfFlag), 72'd0, "R8 overflow cleared");
    busRdN = 1'b1; drain(); tick(3);

    // R12: accept and new start on the same edge.
    busWrN = 1'b0; busAddr = 23'h0C; busData = 16'h0C0C; tick(3);
    busWrN = 1'b1; tick(3);
    busRdN = 1'b0; busAddr = 23'h0D; busData = 16'h0D0D; tick(2);
    recReady = 1'b1; tick(1); recReady = 1'b0;
    check(72'(ovfFlag), 72'd0, "R12 no overflow when accepted");
    check(72'(recValid), 72'd1, "R12 new record offered");
    check(recData, {expTs, 1'b1, 23'h0D, 16'h0D0D}, "R12 new record contents");
    busRdN = 1'b1; tick(3);

    // R9: reset clears pending record, overflow and timestamp.
    busWrN = 1'b0; tick(3);
    check(72'(ovfFlag), 72'd1, "R9 overflow set before reset");
    rst = 1'b1; busWrN = 1'b1; tick(2); rst = 1'b0; tick(1);
    check(72'(recValid), 72'd0, "R9 valid cleared");
    check(72'(ovfFlag), 72'd0, "R9 overflow cleared");
    tick(3);
    busRdN = 1'b0; tick(3);
    check(72'(recData[71:40]), 72'd0, "R9 timestamp cleared");
    drain(); busRdN = 1'b1; tick(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule